// File: doc/BRIEF.md
# Hardware Spinlock Bank

This block holds a set of single-bit mutual-exclusion flags that several bus masters share. Each master reaches the bank through its own simple request port: a request carries a valid bit, a write flag, a 12-bit byte address and 32 bits of write data. The response comes back one cycle later. Software takes a lock by reading its register. If the read returns 0, the caller now owns the lock, and that same access has already marked the lock taken. The owner hands the lock back by writing 0 to the same register.

A read-only status word tells software how large the bank is. The lock count is a parameter. The status word encodes it as a one-hot multiple of 32, so the same software can run on banks of 32, 64, 128 or 256 locks. All ports are resolved in the same cycle with a fixed order, so two masters can never both be handed the same lock.

Top module: `hwlock_bank`

## Requirements
- R1: After reset every lock is free, so the first read of any lock returns 0.
- R2: A read of a free lock at byte offset 0x800 + 4*i returns 0 in bit 0 (all other bits 0) and marks lock i taken. Every later read of that lock returns 1 until the lock is released.
- R3: A write of 0 to a lock register frees that lock. A write of any nonzero value to a lock register leaves the lock unchanged.
- R4: When several ports read the same free lock in one cycle, the lowest-numbered port receives 0 and every other port receives 1. A read of a taken lock changes nothing.
- R5: When a release and a read of the same lock fall in the same cycle, the release applies first. The read then returns 0 and leaves the lock taken.
- R6: A read of byte offset 0x014 returns NUM_LOCKS/32 in bits [27:24] and 0 in all other bits. Writes to this offset have no effect.
- R7: Address bits [1:0] are ignored. Reads of any other offset, and of lock indices at or above NUM_LOCKS, return 0. Writes to those addresses change no lock.
- R8: Each request on port p produces resp_valid[p] with its data exactly one cycle later. A write's response data is 0, and no response appears without a request.
- R9: Acquiring or releasing one lock never changes the state of any other lock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NUM_PORTS | Request strobe, one bit per port |
| req_write | input | NUM_PORTS | 1 = write, 0 = read, one bit per port |
| req_addr | input | 12*NUM_PORTS | Byte address, port p in bits [12p+11:12p] |
| req_wdata | input | 32*NUM_PORTS | Write data, port p in bits [32p+31:32p] |
| resp_valid | output | NUM_PORTS | Response strobe, one cycle after the request |
| resp_rdata | output | 32*NUM_PORTS | Read data, port p in bits [32p+31:32p] |

## Verification
Directed cycles take a single lock through acquire, a repeated read, a rejected nonzero write and a release. This separates the read side effect from the write path. Same-cycle patterns have both ports read one free lock, and one port release a lock while the other reads it. These expose the port priority and the release-before-acquire ordering. Address probes at the status word, at the last valid lock, above NUM_LOCKS, in the unmapped upper page and with unaligned low bits tell the decode cases apart. A seeded random run then has both ports hammer a small group of locks with mixed reads, zero writes and nonzero writes, and compares every response against a reference model of the lock bits. That run is what checks that two masters never both hold a lock between releases.

// File: rtl/hwlock_pkg.sv
package hwlock_pkg;
    localparam int ADDR_W     = 12;
    localparam int DATA_W     = 32;
    localparam int IDX_MAX_W  = 8;
    localparam logic [ADDR_W-1:0] STATUS_ADDR = 12'h014;
    localparam int CNT_LSB    = 24;

    typedef struct packed {
        logic                 valid;
        logic                 write;
        logic [ADDR_W-1:0]    addr;
        logic [DATA_W-1:0]    wdata;
    } bus_req_t;

    typedef struct packed {
        logic                 rd_lock;
        logic                 wr_lock;
        logic                 rd_status;
        logic                 is_write;
        logic [IDX_MAX_W-1:0] idx;
        logic [DATA_W-1:0]    wdata;
    } dec_t;

    function automatic logic [DATA_W-1:0] status_word(input int num_locks);
        logic [DATA_W-1:0] w;
        w = '0;
        w[CNT_LSB +: 4] = 4'(num_locks / 32);
        return w;
    endfunction
endpackage

// File: rtl/hwlock_decode.sv
module hwlock_decode
    import hwlock_pkg::*;
#(
    parameter int NUM_LOCKS = 64
) (
    input  bus_req_t req,
    output dec_t     dec
);
    localparam logic [IDX_MAX_W:0] LIMIT = (IDX_MAX_W+1)'(NUM_LOCKS);

    logic [IDX_MAX_W-1:0] field;
    logic                 in_lock_page;
    logic                 lock_hit;
    logic                 status_hit;

    always_comb begin
        field        = req.addr[2 +: IDX_MAX_W];
        in_lock_page = (req.addr[ADDR_W-1 -: 2] == 2'b10);
        lock_hit     = req.valid && in_lock_page && ({1'b0, field} < LIMIT);
        status_hit   = req.valid && (req.addr[ADDR_W-1:2] == STATUS_ADDR[ADDR_W-1:2]);

        dec.rd_lock   = lock_hit && !req.write;
        dec.wr_lock   = lock_hit && req.write;
        dec.rd_status = status_hit && !req.write;
        dec.is_write  = req.valid && req.write;
        dec.idx       = field;
        dec.wdata     = req.wdata;
    end
endmodule

// File: rtl/hwlock_array.sv
module hwlock_array
    import hwlock_pkg::*;
#(
    parameter int NUM_LOCKS = 64,
    parameter int NUM_PORTS = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  dec_t                 dec   [NUM_PORTS],
    output logic [NUM_PORTS-1:0] rd_bit
);
    localparam int IDX_W = $clog2(NUM_LOCKS);

    logic [NUM_LOCKS-1:0] lock_q;
    logic [NUM_LOCKS-1:0] lock_d;
    logic [NUM_LOCKS-1:0] rel_mask;
    logic [NUM_LOCKS-1:0] acq_mask;
    logic [NUM_PORTS-1:0] grant;

    // Releases first, then reads in ascending port order.
    always_comb begin
        logic [NUM_LOCKS-1:0] cur;
        rel_mask = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (dec[p].wr_lock && (dec[p].wdata == '0))
                rel_mask[dec[p].idx[IDX_W-1:0]] = 1'b1;
        end
        cur      = lock_q & ~rel_mask;
        acq_mask = '0;
        grant    = '0;
        rd_bit   = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (dec[p].rd_lock) begin
                rd_bit[p] = cur[dec[p].idx[IDX_W-1:0]];
                if (!cur[dec[p].idx[IDX_W-1:0]]) begin
                    grant[p] = 1'b1;
                    acq_mask[dec[p].idx[IDX_W-1:0]] = 1'b1;
                end
                cur[dec[p].idx[IDX_W-1:0]] = 1'b1;
            end
        end
        lock_d = cur;
    end

    always_ff @(posedge clk) begin
        if (rst) lock_q <= '0;
        else     lock_q <= lock_d;
    end

    // R1: every lock is free right after reset
    a_r1_reset_free: assert property (@(posedge clk)
        $past(rst) && !rst |-> lock_q == '0);

    // R2/R3/R9: a taken lock stays taken unless a zero write released it
    a_r3_hold_taken: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(lock_q & ~rel_mask) & ~lock_q) == '0));

    // R2/R9: a lock only becomes taken through a granted read
    a_r9_no_spurious_set: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((lock_q & ~$past(lock_q) & ~$past(acq_mask)) == '0));

    // R4: no two ports are granted the same lock in one cycle
    generate
        for (genvar a = 0; a < NUM_PORTS; a++) begin : g_pa
            for (genvar b = a + 1; b < NUM_PORTS; b++) begin : g_pb
                a_r4_mutex: assert property (@(posedge clk) disable iff (rst)
                    (dec[a].rd_lock && dec[b].rd_lock && dec[a].idx == dec[b].idx)
                    |-> !(grant[a] && grant[b]));
            end
        end
    endgenerate
endmodule

// File: rtl/hwlock_bank.sv
module hwlock_bank
    import hwlock_pkg::*;
#(
    parameter int NUM_LOCKS = 64,
    parameter int NUM_PORTS = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_PORTS-1:0]        req_valid,
    input  logic [NUM_PORTS-1:0]        req_write,
    input  logic [NUM_PORTS*ADDR_W-1:0] req_addr,
    input  logic [NUM_PORTS*DATA_W-1:0] req_wdata,
    output logic [NUM_PORTS-1:0]        resp_valid,
    output logic [NUM_PORTS*DATA_W-1:0] resp_rdata
);
    localparam logic [DATA_W-1:0] STATUS_VAL = status_word(NUM_LOCKS);

    bus_req_t             req [NUM_PORTS];
    dec_t                 dec [NUM_PORTS];
    logic [NUM_PORTS-1:0] rd_bit;

    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
            logic [DATA_W-1:0] rdata_d;

            always_comb begin
                req[p].valid = req_valid[p];
                req[p].write = req_write[p];
                req[p].addr  = req_addr[p*ADDR_W +: ADDR_W];
                req[p].wdata = req_wdata[p*DATA_W +: DATA_W];
            end

            hwlock_decode #(.NUM_LOCKS(NUM_LOCKS)) u_dec (
                .req (req[p]),
                .dec (dec[p])
            );

            always_comb begin
                rdata_d = '0;
                if (dec[p].rd_status)    rdata_d = STATUS_VAL;
                else if (dec[p].rd_lock) rdata_d = {{(DATA_W-1){1'b0}}, rd_bit[p]};
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    resp_valid[p]                    <= 1'b0;
                    resp_rdata[p*DATA_W +: DATA_W]   <= '0;
                end else begin
                    resp_valid[p]                    <= req_valid[p];
                    resp_rdata[p*DATA_W +: DATA_W]   <= rdata_d;
                end
            end

            // R8: one response per request, one cycle later
            a_r8_resp_follows: assert property (@(posedge clk) disable iff (rst)
                req_valid[p] |=> resp_valid[p]);
            a_r8_no_stray_resp: assert property (@(posedge clk) disable iff (rst)
                !req_valid[p] |=> !resp_valid[p]);
            // R8: write responses carry zero data
            a_r8_write_zero: assert property (@(posedge clk) disable iff (rst)
                (req_valid[p] && req_write[p]) |=> resp_rdata[p*DATA_W +: DATA_W] == '0);
            // R6: status read returns the size code
            a_r6_status: assert property (@(posedge clk) disable iff (rst)
                (req_valid[p] && !req_write[p] &&
                 req_addr[p*ADDR_W+2 +: ADDR_W-2] == STATUS_ADDR[ADDR_W-1:2])
                |=> resp_rdata[p*DATA_W +: DATA_W] == STATUS_VAL);
            // R7: the upper page is unmapped
            a_r7_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
                (req_valid[p] && !req_write[p] &&
                 req_addr[p*ADDR_W+ADDR_W-2 +: 2] == 2'b11)
                |=> resp_rdata[p*DATA_W +: DATA_W] == '0);
        end
    endgenerate

    hwlock_array #(.NUM_LOCKS(NUM_LOCKS), .NUM_PORTS(NUM_PORTS)) u_array (
        .clk    (clk),
        .rst    (rst),
        .dec    (dec),
        .rd_bit (rd_bit)
    );
endmodule

// File: tb/hwlock_bank_tb.sv
`timescale 1ns/1ps
module hwlock_bank_tb;
    localparam int NL = 64;
    localparam int NP = 2;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NP-1:0]   req_valid = '0;
    logic [NP-1:0]   req_write = '0;
    logic [NP*12-1:0] req_addr = '0;
    logic [NP*32-1:0] req_wdata = '0;
    logic [NP-1:0]   resp_valid;
    logic [NP*32-1:0] resp_rdata;

    int n_cmp = 0;
    int n_bad = 0;
    logic [NL-1:0] model = '0;
    logic [NL-1:0] owned_since_rel;

    always #4 clk = ~clk;

    hwlock_bank #(.NUM_LOCKS(NL), .NUM_PORTS(NP)) u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata)
    );

    function automatic bit lock_hit(input logic [11:0] a, output int i);
        i = int'(a[9:2]);
        return (a[11:10] == 2'b10) && (i < NL);
    endfunction

    function automatic bit is_status(input logic [11:0] a);
        return a[11:2] == 10'h005;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    // One bus cycle on both ports; the model predicts the responses.
    task automatic cyc(input string tag,
                       input bit v0, input bit w0, input logic [11:0] a0, input logic [31:0] d0,
                       input bit v1, input bit w1, input logic [11:0] a1, input logic [31:0] d1);
        bit v[NP]; bit w[NP]; logic [11:0] a[NP]; logic [31:0] d[NP];
        logic [31:0] exp_d[NP];
        int idx;
        v[0]=v0; w[0]=w0; a[0]=a0; d[0]=d0;
        v[1]=v1; w[1]=w1; a[1]=a1; d[1]=d1;
        @(negedge clk);
        for (int p = 0; p < NP; p++) begin
            req_valid[p] = v[p];
            req_write[p] = w[p];
            req_addr[p*12 +: 12] = a[p];
            req_wdata[p*32 +: 32] = d[p];
        end
        for (int p = 0; p < NP; p++)
            if (v[p] && w[p] && d[p] == 0 && lock_hit(a[p], idx)) begin
                model[idx] = 1'b0;
                owned_since_rel[idx] = 1'b0;
            end
        for (int p = 0; p < NP; p++) begin
            exp_d[p] = 32'h0;
            if (v[p] && !w[p]) begin
                if (is_status(a[p])) exp_d[p] = 32'(NL / 32) << 24;
                else if (lock_hit(a[p], idx)) begin
                    exp_d[p] = {31'h0, model[idx]};
                    if (!model[idx]) begin
                        if (owned_since_rel[idx]) begin
                            n_bad++;
                            $display("FAIL R4: lock %0d granted twice, actual 1 expected 0", idx);
                        end
                        owned_since_rel[idx] = 1'b1;
                    end
                    model[idx] = 1'b1;
                end
            end
        end
        @(posedge clk); #1;
        for (int p = 0; p < NP; p++) begin
            check({tag, " valid"}, {31'h0, resp_valid[p]}, {31'h0, v[p]});
            if (v[p]) check(tag, resp_rdata[p*32 +: 32], exp_d[p]);
        end
    endtask

    function automatic logic [11:0] la(input int i);
        return 12'h800 + 12'(4 * i);
    endfunction

    initial begin
        owned_since_rel = '0;
        repeat (3) @(posedge clk);
        #1 check("R8 reset", {30'h0, resp_valid}, 32'h0);
        @(negedge clk) rst = 1'b0;

        cyc("R1 first read", 1,0,la(0),0, 0,0,0,0);
        cyc("R2 reread",     1,0,la(0),0, 1,0,la(0),0);
        cyc("R3 nonzero write", 1,1,la(0),32'h5, 0,0,0,0);
        cyc("R3 still taken", 0,0,0,0, 1,0,la(0),0);
        cyc("R9 other lock free", 1,0,la(1),0, 0,0,0,0);
        cyc("R3 release", 0,0,0,0, 1,1,la(0),0);
        cyc("R3 free again", 0,0,0,0, 1,0,la(0),0);
        cyc("R4 same cycle", 1,0,la(5),0, 1,0,la(5),0);
        cyc("R5 release+read", 1,1,la(5),0, 1,0,la(5),0);
        cyc("R5 taken after", 1,0,la(5),0, 0,0,0,0);
        cyc("R6 status", 1,0,12'h014,0, 1,0,12'h016,0);
        cyc("R6 status write", 1,1,12'h014,32'hFFFF_FFFF, 0,0,0,0);
        cyc("R6 status stable", 0,0,0,0, 1,0,12'h014,0);
        cyc("R7 above range", 1,0,la(NL),0, 1,0,12'hC00,0);
        cyc("R7 write ignored", 1,1,la(NL),0, 1,1,12'h020,0);
        cyc("R7 low bits ignored", 1,0,12'h803,0, 0,0,0,0);
        cyc("R2 last lock", 1,0,la(NL-1),0, 0,0,0,0);
        cyc("R2 last lock taken", 0,0,0,0, 1,0,la(NL-1),0);
        cyc("R8 idle", 0,0,0,0, 0,0,0,0);

        void'($urandom(32'd1234));
        for (int k = 0; k < 600; k++) begin
            bit v[NP]; bit w[NP]; logic [11:0] a[NP]; logic [31:0] d[NP];
            for (int p = 0; p < NP; p++) begin
                int r;
                r = $urandom_range(0, 19);
                v[p] = (r != 0);
                w[p] = (r >= 13);
                a[p] = (r == 19) ? 12'($urandom_range(0, 4095)) : la($urandom_range(8, 11));
                d[p] = ($urandom_range(0, 4) == 0) ? 32'($urandom_range(1, 255)) : 32'h0;
            end
            cyc("R4 random", v[0],w[0],a[0],d[0], v[1],w[1],a[1],d[1]);
        end
        req_valid = '0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule